// File: doc/BRIEF.md
# Power-Management Register Block with SMI Request

This block is a byte-wide register file for power management, reached over a simple I/O bus carrying an address, separate read and write strobes, and 8-bit write and read data. It answers a 128-byte window whose start is set by a base-address input, and it ignores all traffic while its enable input is low. It holds these registers: a PM status register, a PM control register, a global status register, a global enable register and a global control register. It also holds a timer reload enable register, a 32-bit general-purpose output port and two read-only views: a 32-bit general-purpose input port and a 16-bit external SMI input value.

Registers wider than one byte sit at consecutive byte addresses, least significant byte first. Software writes them one byte lane at a time, and a fixed mask clears the bits each register does not implement. Software can hand control to the firmware by setting a release bit in PM control and writing offset 0x04. That write sets a BIOS status bit in global status and, if the matching enable bit is set, raises a level SMI request. The request stays high until software clears the status bit.

Top module: `pm_regblock`

## Requirements
- R1: An access takes effect only while `en` is 1 and `base <= addr <= base+0x7F`. The offset is `addr-base`, and only its low 7 bits are decoded. Outside the window, or while `en` is 0, writes change nothing and a read returns `rdata`=0x00 with `rd_ack`=0. Inside, a read gives `rd_ack`=1.
- R2: Register layout by offset, least significant byte at the lowest offset. PM status is 16 bits at 0x00–0x01. PM control is 16 bits at 0x04–0x05. Global status is 32 bits at 0x20–0x23. Global enable is 32 bits at 0x24–0x27. Global control is 32 bits at 0x28–0x2B. For 32-bit registers the byte lane is offset[1:0] and the bit shift is lane×8. For 16-bit registers the lane is offset[0]. A byte write changes only its own lane.
- R3: Writes to 0x4C–0x4F update the matching byte of the output port, and the stored value is ANDed with 0x7FFFFFFF. Reads of 0x4C–0x4F return the stored bytes, and `gpo_out` always shows the stored value.
- R4: After reset the output port holds 0x7FFFFFFF, every other register holds 0, and `smi_req` is 0.
- R5: Reads of 0x48–0x4B return the bytes of `gpi_in`, lane offset[1:0]. Writes there have no effect.
- R6: Reads of 0x44–0x45 return the bytes of `extsmi_in`, lane offset[0].
- R7: The timer reload enable register sits at 0x38–0x3B. It is written bytewise, and the stored 32-bit value is ANDed with 0x000000D9.
- R8: A write to offset 0x04 whose data has bit 2 set (the release bit of PM control) sets global status bit 5. If global enable bit 5 is 1 at that time, `smi_req` goes to 1 on the same clock edge. A write to 0x05 triggers nothing.
- R9: A write to offset 0x00 whose data leaves PM status bit 5 at 0 clears global control bit 1. If the written bit 5 is 1, global control is unchanged.
- R10: Global status is write-one-to-clear: a written 1 clears the bit and a written 0 leaves it. `smi_req` is a level. It stays high until a write to offset 0x20 with data bit 5 set clears global status bit 5.
- R11: Reads of any offset not listed above return 0x00 with `rd_ack`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Decode enable |
| base | input | 16 | Start address of the 128-byte window |
| addr | input | 16 | Bus address |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| rd_ack | output | 1 | Read hit the window |
| gpi_in | input | 32 | General-purpose input port |
| extsmi_in | input | 16 | External SMI input levels |
| gpo_out | output | 32 | General-purpose output port |
| smi_req | output | 1 | SMI request level |

## Verification
All 128 offsets are read back after reset and again after each of two full write sweeps that use complementary data patterns. These sweeps tell apart wrong lane placement, bits leaking past a mask, writes landing on read-only views and decode aliasing. Directed sequences drive the release write with the enable bit on and off, writes of zero and one to the status bit, and the 0x00 write with bit 5 set and clear. This shows that SMI sets, holds and clears correctly. Accesses just below and just above the window, and accesses with the enable input low, show that out-of-window writes are dropped and out-of-window reads stay silent.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int OFFW = 7;
  localparam int WIN_BYTES = 1 << OFFW;

  localparam logic [OFFW-1:0] OFS_PMSTS = 7'h00;
  localparam logic [OFFW-1:0] OFS_PMCTL = 7'h04;
  localparam logic [OFFW-1:0] OFS_GSTS  = 7'h20;
  localparam logic [OFFW-1:0] OFS_GEN   = 7'h24;
  localparam logic [OFFW-1:0] OFS_GCTL  = 7'h28;
  localparam logic [OFFW-1:0] OFS_GPT   = 7'h38;
  localparam logic [OFFW-1:0] OFS_EXT   = 7'h44;
  localparam logic [OFFW-1:0] OFS_GPI   = 7'h48;
  localparam logic [OFFW-1:0] OFS_GPO   = 7'h4C;

  localparam logic [31:0] GPT_MASK = 32'h0000_00D9;
  localparam logic [31:0] GPO_MASK = 32'h7FFF_FFFF;
  localparam logic [31:0] GPO_RST  = 32'h7FFF_FFFF;

  localparam int STS_BIOS_BIT = 5;
  localparam int CTL_RLS_BIT  = 2;
  localparam int GCTL_RLS_BIT = 1;

  function automatic logic in_block(input logic [OFFW-1:0] off,
                                    input logic [OFFW-1:0] start,
                                    input int nbytes);
    int o;
    int s;
    o = int'(off);
    s = int'(start);
    return (o >= s) && (o < s + nbytes);
  endfunction

  function automatic logic [7:0] lane_pick(input logic [31:0] val,
                                           input logic [1:0] lane);
    return val[int'(lane)*8 +: 8];
  endfunction
endpackage

// File: rtl/pm_window.sv
module pm_window #(
  parameter int AW = 16,
  parameter int WIN_BYTES = 128,
  localparam int OW = $clog2(WIN_BYTES)
) (
  input  logic          en,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [OW-1:0] off
);
  logic [AW:0] diff;

  always_comb begin
    diff = {1'b0, addr} - {1'b0, base};
    hit  = en && !diff[AW] && (diff < (AW+1)'(WIN_BYTES));
    off  = diff[OW-1:0];
  end
endmodule

// File: rtl/pm_lane_reg.sv
module pm_lane_reg #(
  parameter int W = 32,
  parameter logic [W-1:0] MASK = '1,
  parameter logic [W-1:0] RST = '0,
  parameter bit W1C = 1'b0,
  localparam int LANES = W / 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [1:0]   lane,
  input  logic [7:0]   wdata,
  input  logic [W-1:0] hw_set,
  input  logic [W-1:0] hw_clr,
  output logic [W-1:0] q
);
  int sh;
  logic [W-1:0] lane_mask, lane_data, wr_val, nxt;

  always_comb begin
    sh        = (int'(lane) % LANES) * 8;
    lane_mask = {{(W-8){1'b0}}, 8'hFF} << sh;
    lane_data = {{(W-8){1'b0}}, wdata} << sh;
  end

  generate
    if (W1C) begin : g_w1c
      assign wr_val = q & ~lane_data;
    end else begin : g_plain
      assign wr_val = (q & ~lane_mask) | lane_data;
    end
  endgenerate

  always_comb begin
    nxt = we ? wr_val : q;
    nxt = ((nxt | hw_set) & ~hw_clr) & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST;
    else        q <= nxt;
  end
endmodule

// File: rtl/pm_regblock.sv
module pm_regblock
  import pm_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          rd_ack,
  input  logic [31:0]   gpi_in,
  input  logic [15:0]   extsmi_in,
  output logic [31:0]   gpo_out,
  output logic          smi_req
);
  logic            hit;
  logic [OFFW-1:0] off;
  logic [1:0]      lane;
  logic            wr_hit;

  pm_window #(.AW(AW), .WIN_BYTES(WIN_BYTES)) u_win (
    .en(en), .base(base), .addr(addr), .hit(hit), .off(off)
  );

  assign lane   = off[1:0];
  assign wr_hit = wr && hit;

  // Named internal events used by the assertions
  logic we_pst, we_pct, we_gst, we_gen, we_gct, we_gpt, gpo_wr;
  logic bios_trig, rls_clr, sts5_clr;

  assign we_pst = wr_hit && in_block(off, OFS_PMSTS, 2);
  assign we_pct = wr_hit && in_block(off, OFS_PMCTL, 2);
  assign we_gst = wr_hit && in_block(off, OFS_GSTS, 4);
  assign we_gen = wr_hit && in_block(off, OFS_GEN, 4);
  assign we_gct = wr_hit && in_block(off, OFS_GCTL, 4);
  assign we_gpt = wr_hit && in_block(off, OFS_GPT, 4);
  assign gpo_wr = wr_hit && in_block(off, OFS_GPO, 4);

  assign bios_trig = wr_hit && (off == OFS_PMCTL) && wdata[CTL_RLS_BIT];
  assign rls_clr   = wr_hit && (off == OFS_PMSTS) && !wdata[STS_BIOS_BIT];
  assign sts5_clr  = wr_hit && (off == OFS_GSTS) && wdata[STS_BIOS_BIT];

  logic [15:0] pst_q, pct_q;
  logic [31:0] gst_q, gen_q, gct_q, gpt_q;

  pm_lane_reg #(.W(16)) u_pst (
    .clk(clk), .rst_n(rst_n), .we(we_pst), .lane(lane), .wdata(wdata),
    .hw_set('0), .hw_clr('0), .q(pst_q)
  );

  pm_lane_reg #(.W(16)) u_pct (
    .clk(clk), .rst_n(rst_n), .we(we_pct), .lane(lane), .wdata(wdata),
    .hw_set('0), .hw_clr('0), .q(pct_q)
  );

  pm_lane_reg #(.W(32), .W1C(1'b1)) u_gst (
    .clk(clk), .rst_n(rst_n), .we(we_gst), .lane(lane), .wdata(wdata),
    .hw_set(32'(bios_trig) << STS_BIOS_BIT), .hw_clr('0), .q(gst_q)
  );

  pm_lane_reg #(.W(32)) u_gen (
    .clk(clk), .rst_n(rst_n), .we(we_gen), .lane(lane), .wdata(wdata),
    .hw_set('0), .hw_clr('0), .q(gen_q)
  );

  pm_lane_reg #(.W(32)) u_gct (
    .clk(clk), .rst_n(rst_n), .we(we_gct), .lane(lane), .wdata(wdata),
    .hw_set('0), .hw_clr(32'(rls_clr) << GCTL_RLS_BIT), .q(gct_q)
  );

  pm_lane_reg #(.W(32), .MASK(GPT_MASK)) u_gpt (
    .clk(clk), .rst_n(rst_n), .we(we_gpt), .lane(lane), .wdata(wdata),
    .hw_set('0), .hw_clr('0), .q(gpt_q)
  );

  pm_lane_reg #(.W(32), .MASK(GPO_MASK), .RST(GPO_RST)) u_gpo (
    .clk(clk), .rst_n(rst_n), .we(gpo_wr), .lane(lane), .wdata(wdata),
    .hw_set('0), .hw_clr('0), .q(gpo_out)
  );

  // SMI request: level, set by the release write, cleared via status W1C
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              smi_req <= 1'b0;
    else if (bios_trig && gen_q[STS_BIOS_BIT]) smi_req <= 1'b1;
    else if (sts5_clr)                       smi_req <= 1'b0;
  end

  // Read path
  logic [7:0] rd_byte;

  always_comb begin
    rd_byte = 8'h00;
    if (in_block(off, OFS_PMSTS, 2))     rd_byte = lane_pick({16'h0, pst_q}, {1'b0, lane[0]});
    else if (in_block(off, OFS_PMCTL, 2)) rd_byte = lane_pick({16'h0, pct_q}, {1'b0, lane[0]});
    else if (in_block(off, OFS_GSTS, 4))  rd_byte = lane_pick(gst_q, lane);
    else if (in_block(off, OFS_GEN, 4))   rd_byte = lane_pick(gen_q, lane);
    else if (in_block(off, OFS_GCTL, 4))  rd_byte = lane_pick(gct_q, lane);
    else if (in_block(off, OFS_GPT, 4))   rd_byte = lane_pick(gpt_q, lane);
    else if (in_block(off, OFS_EXT, 2))   rd_byte = lane_pick({16'h0, extsmi_in}, {1'b0, lane[0]});
    else if (in_block(off, OFS_GPI, 4))   rd_byte = lane_pick(gpi_in, lane);
    else if (in_block(off, OFS_GPO, 4))   rd_byte = lane_pick(gpo_out, lane);
  end

  assign rd_ack = rd && hit;
  assign rdata  = rd_ack ? rd_byte : 8'h00;

  // Assertions
  p_rd_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !hit) |-> (rdata == 8'h00));

  p_gpo_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !gpo_wr |=> $stable(gpo_out));

  p_bios_sts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bios_trig |=> gst_q[STS_BIOS_BIT]);

  p_smi_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bios_trig && gen_q[STS_BIOS_BIT]) |=> smi_req);

  p_rls_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rls_clr |=> !gct_q[GCTL_RLS_BIT]);

  p_smi_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_req && !sts5_clr) |=> smi_req);

  p_smi_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sts5_clr && !bios_trig) |=> !smi_req);
endmodule

// File: tb/pm_regblock_test.sv
module pm_regblock_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] base, addr;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        rd_ack;
  logic [31:0] gpi_in;
  logic [15:0] extsmi_in;
  logic [31:0] gpo_out;
  logic        smi_req;

  always #2 clk = ~clk;

  localparam logic [15:0] BASE = 16'h0300;
  localparam logic [31:0] GPI  = 32'hA5C3_1E78;
  localparam logic [15:0] EXT  = 16'hBEEF;

  pm_regblock uut (
    .clk(clk), .rst_n(rst_n), .en(en), .base(base), .addr(addr),
    .wr(wr), .rd(rd), .wdata(wdata), .rdata(rdata), .rd_ack(rd_ack),
    .gpi_in(gpi_in), .extsmi_in(extsmi_in), .gpo_out(gpo_out), .smi_req(smi_req)
  );

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [15:0] m_pst, m_pct;
  logic [31:0] m_gst, m_gen, m_gct, m_gpt, m_gpo;
  logic        m_smi;

  function automatic logic [7:0] b32(input logic [31:0] v, input int l);
    return v[l*8 +: 8];
  endfunction

  function automatic logic [7:0] exp_rd(input int o);
    if (o < 2)                return b32({16'h0, m_pst}, o % 2);
    if (o == 4 || o == 5)     return b32({16'h0, m_pct}, o % 2);
    if (o >= 32 && o < 36)    return b32(m_gst, o - 32);
    if (o >= 36 && o < 40)    return b32(m_gen, o - 36);
    if (o >= 40 && o < 44)    return b32(m_gct, o - 40);
    if (o >= 56 && o < 60)    return b32(m_gpt, o - 56);
    if (o == 68 || o == 69)   return b32({16'h0, EXT}, o - 68);
    if (o >= 72 && o < 76)    return b32(GPI, o - 72);
    if (o >= 76 && o < 80)    return b32(m_gpo, o - 76);
    return 8'h00;
  endfunction

  task automatic model_wr(input int o, input logic [7:0] d);
    int l;
    l = o % 4;
    if (o < 2) begin
      m_pst[(o % 2)*8 +: 8] = d;
      if (o == 0 && !d[5]) m_gct[1] = 1'b0;
    end else if (o == 4 || o == 5) begin
      m_pct[(o % 2)*8 +: 8] = d;
      if (o == 4 && d[2]) begin
        m_gst[5] = 1'b1;
        if (m_gen[5]) m_smi = 1'b1;
      end
    end else if (o >= 32 && o < 36) begin
      m_gst = m_gst & ~({24'h0, d} << (8*l));
      if (o == 32 && d[5]) m_smi = 1'b0;
    end else if (o >= 36 && o < 40) m_gen[8*l +: 8] = d;
    else if (o >= 40 && o < 44) m_gct[8*l +: 8] = d;
    else if (o >= 56 && o < 60) begin
      m_gpt[8*l +: 8] = d;
      m_gpt = m_gpt & 32'h0000_00D9;
    end else if (o >= 76 && o < 80) begin
      m_gpo[8*l +: 8] = d;
      m_gpo = m_gpo & 32'h7FFF_FFFF;
    end
  endtask

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wr_off(input int o, input logic [7:0] d);
    bus_wr(BASE + 16'(o), d);
    model_wr(o, d);
  endtask

  task automatic rd_chk(input int o, input string tag);
    logic [7:0] e;
    @(negedge clk);
    addr = BASE + 16'(o); rd = 1'b1;
    #1;
    e = exp_rd(o);
    check(rd_ack && rdata == e, tag, {23'h0, rd_ack, rdata}, {23'h0, 1'b1, e});
    rd = 1'b0;
  endtask

  task automatic rd_silent(input logic [15:0] a, input string tag);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1;
    check(!rd_ack && rdata == 8'h00, tag, {23'h0, rd_ack, rdata}, 32'h0);
    rd = 1'b0;
  endtask

  task automatic pins_chk(input string tag);
    #1;
    check(smi_req == m_smi, {tag, " smi"}, {31'h0, smi_req}, {31'h0, m_smi});
    check(gpo_out == m_gpo, {tag, " gpo"}, gpo_out, m_gpo);
  endtask

  task automatic sweep(input string tag);
    for (int o = 0; o < 128; o++) rd_chk(o, tag);
  endtask

  initial begin
    base = BASE; addr = 16'h0; gpi_in = GPI; extsmi_in = EXT;
    m_pst = 0; m_pct = 0; m_gst = 0; m_gen = 0; m_gct = 0; m_gpt = 0;
    m_gpo = 32'h7FFF_FFFF; m_smi = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; en = 1'b1;

    // Reset state: R4, plus read-only views R5 R6 and holes R11
    pins_chk("R4 reset");
    sweep("R4 R5 R6 R11 reset sweep");

    // Write sweep with two complementary patterns: R2 R3 R5 R7 R10
    for (int o = 0; o < 128; o++) wr_off(o, 8'((o*37 + 5) & 255));
    pins_chk("R3 R10 sweep1");
    sweep("R2 R3 R5 R7 R10 sweep1");
    for (int o = 0; o < 128; o++) wr_off(o, ~8'((o*37 + 5) & 255));
    pins_chk("R3 R10 sweep2");
    sweep("R2 R3 R7 R11 sweep2");

    // Clean start for the handshake tests
    for (int o = 32; o < 36; o++) wr_off(o, 8'hFF);
    for (int o = 36; o < 44; o++) wr_off(o, 8'h00);
    pins_chk("R10 clear all");

    // R8: release write with enable on raises SMI
    wr_off(36, 8'h20);
    wr_off(4, 8'h04);
    pins_chk("R8 trigger enabled");
    rd_chk(32, "R8 bios status set");
    // R10: writing zero keeps SMI, writing one clears it
    wr_off(32, 8'h00);
    pins_chk("R10 w0 holds");
    wr_off(32, 8'h20);
    pins_chk("R10 w1 clears");
    rd_chk(32, "R10 status cleared");

    // R8: enable off -> status only; 0x05 write never triggers
    wr_off(36, 8'h00);
    wr_off(4, 8'h04);
    pins_chk("R8 trigger disabled");
    rd_chk(32, "R8 status without smi");
    wr_off(32, 8'h20);
    wr_off(36, 8'h20);
    wr_off(5, 8'h04);
    pins_chk("R8 upper byte no trigger");
    rd_chk(32, "R8 upper byte status");

    // R9: release-bit clear conditioned on PM status bit 5
    wr_off(40, 8'h02);
    wr_off(0, 8'h20);
    rd_chk(40, "R9 bit5 set keeps");
    wr_off(0, 8'h00);
    rd_chk(40, "R9 bit5 clear clears");

    // R1: out-of-window and disabled accesses are ignored
    bus_wr(BASE - 16'h1, 8'h00);
    bus_wr(BASE + 16'h80 + 16'h4C, 8'h00);
    bus_wr(BASE + 16'h80, 8'hFF);
    @(negedge clk); en = 1'b0;
    bus_wr(BASE + 16'h4C, 8'h00);
    bus_wr(BASE + 16'h04, 8'h04);
    rd_silent(BASE + 16'h4C, "R1 disabled read");
    @(negedge clk); en = 1'b1;
    pins_chk("R1 ignored writes");
    rd_chk(76, "R1 gpo intact");
    rd_chk(0, "R1 offset0 intact");
    rd_silent(BASE - 16'h1, "R1 below window");
    rd_silent(BASE + 16'h80, "R1 above window");
    rd_chk(127, "R1 R11 last offset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule